// File: doc/BRIEF.md
# Page Write Buffer with In-Page Wraparound

This block is the receiving end of a page-oriented write into a serial nonvolatile memory. After the command decoder has recognised a write instruction and its address, it presents the start address once. The block splits that address into a page number and a byte position within the page. Each data byte that follows is stored at the current byte position, and the position then advances. The page number never changes during a fill. Bytes that run past the last byte of the page therefore fold back to the first byte of the same page.

When chip select returns high, the block starts an internally timed write cycle. The write covers only those bytes that were actually loaded. It issues one commit request per loaded byte to the array model, in ascending column order. It holds a busy flag for a fixed, parameterised number of cycles and then gives a one-cycle done pulse. While busy, all inputs are ignored. The serial shifter, instruction decoding and write protection live in other blocks.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, `busy`, `done` and `commit_vld` are 0.
- R2: An accepted `start_vld` sets the page number to `start_addr >> log2(PAGE_BYTES)` and the column to the low `log2(PAGE_BYTES)` bits, so the first data byte is committed at `start_addr`.
- R3: Each accepted `byte_vld` stores `byte_data` at the current column and then advances the column by one, so consecutive bytes land at consecutive addresses.
- R4: The page number never changes during a fill. A byte after the last column of a page goes to column 0 of the same page, and every commit address of one write cycle carries the same page number.
- R5: A write cycle commits each loaded column exactly once and no other column, in ascending column order, one request per cycle, and only while `busy` is 1.
- R6: When a column is loaded more than once after a wrap, the byte loaded last is the one committed.
- R7: A `cs_rise` while no data byte has been loaded since the last accepted `start_vld` starts no write cycle: `busy` stays 0 and nothing is committed.
- R8: A `cs_rise` after at least one loaded byte makes `busy` 1 from the next cycle for exactly `WRITE_CYCLES` cycles. `done` is 1 for the single cycle after `busy` falls and is 0 at all other times.
- R9: While `busy` is 1, `start_vld`, `byte_vld` and `cs_rise` have no effect, either on the write in progress or on later operations.
- R10: `byte_vld` is ignored unless a `start_vld` has been accepted since the last write cycle or chip-select rise. A following `cs_rise` then starts no write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_vld | input | 1 | Start address valid; opens a fill |
| start_addr | input | ADDR_W | Decoded start address of the write |
| byte_vld | input | 1 | One data byte is valid |
| byte_data | input | DATA_W | Data byte |
| cs_rise | input | 1 | Chip select has returned high (one-cycle pulse) |
| commit_vld | output | 1 | Commit request to the array this cycle |
| commit_addr | output | ADDR_W | Array address of the committed byte |
| commit_data | output | DATA_W | Byte to store |
| busy | output | 1 | Internal write cycle running |
| done | output | 1 | One-cycle pulse at the end of the write cycle |

## Verification
Several properties are checked on every cycle by assertions. Commits appear only while busy, in strictly rising column order, and all under one page number. Each busy window lasts exactly `WRITE_CYCLES` cycles, and done coincides with the fall of busy. Other behaviours only the bench scenarios can show, because they need a reference model of the stream. These are the exact address and data of each commit, the fold-back past the page end, the rule that the last byte written wins, and the fact that stimulus sent during busy or without an open fill leaves no trace.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
   typedef enum logic [1:0] {
      PB_IDLE  = 2'd0,
      PB_FILL  = 2'd1,
      PB_WRITE = 2'd2
   } pb_state_e;
endpackage

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
   import pwb_pkg::*;
#(
   parameter int WRITE_CYCLES = 24,
   localparam int CNT_W = $clog2(WRITE_CYCLES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_vld,
   input  logic             byte_vld,
   input  logic             cs_rise,
   input  logic             any_loaded,
   output logic             load_addr,
   output logic             take_byte,
   output logic             clr_mask,
   output logic             busy,
   output logic             done,
   output logic [CNT_W-1:0] scan_idx
);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WRITE_CYCLES - 1);

   pb_state_e        state_q, state_d;
   logic [CNT_W-1:0] cnt_q;
   logic             last;
   logic             done_q;

   assign last = (state_q == PB_WRITE) && (cnt_q == LAST_CNT);

   always_comb begin
      state_d   = state_q;
      load_addr = 1'b0;
      take_byte = 1'b0;
      case (state_q)
         PB_IDLE: begin
            if (!cs_rise && start_vld) begin
               load_addr = 1'b1;
               state_d   = PB_FILL;
            end
         end
         PB_FILL: begin
            if (cs_rise) begin
               state_d = any_loaded ? PB_WRITE : PB_IDLE;
            end else if (start_vld) begin
               load_addr = 1'b1;
            end else if (byte_vld) begin
               take_byte = 1'b1;
            end
         end
         PB_WRITE: begin
            if (last) state_d = PB_IDLE;
         end
         default: state_d = PB_IDLE;
      endcase
   end

   assign clr_mask = load_addr | last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PB_IDLE;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= last;
         if (state_q == PB_WRITE) cnt_q <= cnt_q + 1'b1;
         else                     cnt_q <= '0;
      end
   end

   assign busy     = (state_q == PB_WRITE);
   assign done     = done_q;
   assign scan_idx = cnt_q;
endmodule

// File: rtl/pwb_ptr.sv
module pwb_ptr #(
   parameter int ADDR_W = 10,
   parameter int COL_W  = 4,
   localparam int ROW_W = ADDR_W - COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_addr,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              take_byte,
   output logic [ROW_W-1:0]  row,
   output logic [COL_W-1:0]  col
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row <= '0;
         col <= '0;
      end else if (load_addr) begin
         row <= start_addr[ADDR_W-1:COL_W];
         col <= start_addr[COL_W-1:0];
      end else if (take_byte) begin
         col <= col + 1'b1;   // natural fold inside the page
      end
   end
endmodule

// File: rtl/pwb_store.sv
module pwb_store #(
   parameter int PAGE_BYTES = 16,
   parameter int DATA_W     = 8,
   parameter int CNT_W      = 5,
   localparam int COL_W     = $clog2(PAGE_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_mask,
   input  logic              wr_en,
   input  logic [COL_W-1:0]  wr_col,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [CNT_W-1:0]  rd_idx,
   output logic              rd_hit,
   output logic [DATA_W-1:0] rd_data,
   output logic              any_loaded
);
   logic [PAGE_BYTES-1:0] mask_q;
   logic [DATA_W-1:0]     mem_q [PAGE_BYTES];
   logic [COL_W-1:0]      rd_col;
   logic                  in_page;

   for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mask_q[g] <= 1'b0;
            mem_q[g]  <= '0;
         end else if (clr_mask) begin
            mask_q[g] <= 1'b0;
         end else if (wr_en && (wr_col == COL_W'(g))) begin
            mask_q[g] <= 1'b1;
            mem_q[g]  <= wr_data;
         end
      end
   end

   assign rd_col     = rd_idx[COL_W-1:0];
   assign in_page    = (rd_idx < CNT_W'(PAGE_BYTES));
   assign rd_hit     = in_page && mask_q[rd_col];
   assign rd_data    = mem_q[rd_col];
   assign any_loaded = |mask_q;
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
   parameter int ADDR_W       = 10,
   parameter int DATA_W       = 8,
   parameter int PAGE_BYTES   = 16,
   parameter int WRITE_CYCLES = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_vld,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              byte_vld,
   input  logic [DATA_W-1:0] byte_data,
   input  logic              cs_rise,
   output logic              commit_vld,
   output logic [ADDR_W-1:0] commit_addr,
   output logic [DATA_W-1:0] commit_data,
   output logic              busy,
   output logic              done
);
   localparam int COL_W = $clog2(PAGE_BYTES);
   localparam int ROW_W = ADDR_W - COL_W;
   localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

   if (PAGE_BYTES < 2 || (1 << COL_W) != PAGE_BYTES) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two of at least 2");
   end
   if (WRITE_CYCLES < PAGE_BYTES) begin : g_bad_cycles
      $error("WRITE_CYCLES must cover one commit slot per page byte");
   end
   if (ADDR_W <= COL_W) begin : g_bad_addr
      $error("ADDR_W must leave at least one page-number bit");
   end

   logic             load_addr, take_byte, clr_mask, any_loaded, rd_hit;
   logic [CNT_W-1:0] scan_idx;
   logic [ROW_W-1:0] row;
   logic [COL_W-1:0] col;

   pwb_ctrl #(.WRITE_CYCLES(WRITE_CYCLES)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start_vld(start_vld), .byte_vld(byte_vld),
      .cs_rise(cs_rise), .any_loaded(any_loaded), .load_addr(load_addr),
      .take_byte(take_byte), .clr_mask(clr_mask), .busy(busy), .done(done),
      .scan_idx(scan_idx)
   );

   pwb_ptr #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .load_addr(load_addr), .start_addr(start_addr),
      .take_byte(take_byte), .row(row), .col(col)
   );

   pwb_store #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_store (
      .clk(clk), .rst_n(rst_n), .clr_mask(clr_mask), .wr_en(take_byte),
      .wr_col(col), .wr_data(byte_data), .rd_idx(scan_idx), .rd_hit(rd_hit),
      .rd_data(commit_data), .any_loaded(any_loaded)
   );

   assign commit_vld  = busy && rd_hit;
   assign commit_addr = {row, scan_idx[COL_W-1:0]};
endmodule

// File: rtl/pwb_chk.sv
module pwb_chk #(
   parameter int ADDR_W       = 10,
   parameter int PAGE_BYTES   = 16,
   parameter int WRITE_CYCLES = 24,
   localparam int COL_W = $clog2(PAGE_BYTES),
   localparam int RUN_W = $clog2(WRITE_CYCLES + 2)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              commit_vld,
   input logic [ADDR_W-1:0] commit_addr
);
   logic [RUN_W-1:0] run_q;
   logic [COL_W-1:0] last_col_q;
   logic             seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q      <= '0;
         last_col_q <= '0;
         seen_q     <= 1'b0;
      end else begin
         run_q <= busy ? run_q + 1'b1 : '0;
         if (!busy) seen_q <= 1'b0;
         else if (commit_vld) begin
            seen_q     <= 1'b1;
            last_col_q <= commit_addr[COL_W-1:0];
         end
      end
   end

   // R1
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!busy && !done && !commit_vld));

   // R5
   commit_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_vld |-> busy);

   // R5
   commit_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_vld && seen_q) |-> (commit_addr[COL_W-1:0] > last_col_q));

   // R4
   page_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(commit_addr[ADDR_W-1:COL_W]));

   // R8
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_q == RUN_W'(WRITE_CYCLES)));

   // R8
   busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run_q < RUN_W'(WRITE_CYCLES)));

   // R8
   done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R8
   done_only_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $fell(busy));
endmodule

bind page_write_buffer pwb_chk #(
   .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)
) u_pwb_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
   .commit_vld(commit_vld), .commit_addr(commit_addr)
);

// File: tb/tb_page_write_buffer.sv
module tb_page_write_buffer;
   localparam int AW = 10;
   localparam int DW = 8;
   localparam int PG = 16;
   localparam int WC = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_vld = 1'b0;
   logic [AW-1:0] start_addr = '0;
   logic          byte_vld = 1'b0;
   logic [DW-1:0] byte_data = '0;
   logic          cs_rise = 1'b0;
   logic          commit_vld, busy, done;
   logic [AW-1:0] commit_addr;
   logic [DW-1:0] commit_data;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;
   logic [AW+DW-1:0] exp_q [$];

   always #2 clk = ~clk;

   page_write_buffer #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PG), .WRITE_CYCLES(WC)) dut (
      .clk(clk), .rst_n(rst_n), .start_vld(start_vld), .start_addr(start_addr),
      .byte_vld(byte_vld), .byte_data(byte_data), .cs_rise(cs_rise),
      .commit_vld(commit_vld), .commit_addr(commit_addr), .commit_data(commit_data),
      .busy(busy), .done(done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Monitor: scoreboard pop on each commit, busy window length and done pulse.
   int run = 0;
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (commit_vld) begin
               if (exp_q.size() == 0) begin
                  chk(0, "R5 unexpected commit", int'({commit_addr, commit_data}), 0);
               end else begin
                  logic [AW+DW-1:0] e;
                  e = exp_q.pop_front();
                  chk({commit_addr, commit_data} == e, "R5 commit addr/data",
                      int'({commit_addr, commit_data}), int'(e));
               end
            end
            if (busy) run++;
            else if (run > 0) begin
               chk(run == WC, "R8 busy length", run, WC);
               chk(done == 1'b1, "R8 done after busy", int'(done), 1);
               run = 0;
            end else if (done) begin
               chk(0, "R8 stray done", 1, 0);
            end
         end
      end
   end

   task automatic wait_done();
      for (int i = 0; i < 4 * WC; i++) begin
         @(negedge clk);
         if (done) break;
      end
      chk(exp_q.size() == 0, "R5 all loaded bytes committed", exp_q.size(), 0);
      @(negedge clk);
   endtask

   // Driver: one fill, reference model of the page, push expected commits.
   task automatic session(input int a, input int n, input int seed, input bit noise);
      logic [DW-1:0] d [PG];
      bit            m [PG];
      int            row, col0;
      row  = a / PG;
      col0 = a % PG;
      for (int c = 0; c < PG; c++) begin m[c] = 0; d[c] = '0; end
      start_vld = 1'b1; start_addr = AW'(a);
      @(negedge clk);
      start_vld = 1'b0;
      for (int i = 0; i < n; i++) begin
         int c;
         c = (col0 + i) % PG;             // R3 advance, R4 fold within page
         byte_vld = 1'b1; byte_data = DW'(seed + 7 * i);
         m[c] = 1; d[c] = DW'(seed + 7 * i); // R6 last one wins
         @(negedge clk);
      end
      byte_vld = 1'b0;
      for (int c = 0; c < PG; c++)
         if (m[c]) exp_q.push_back({AW'(row * PG + c), d[c]});
      cs_rise = 1'b1;
      @(negedge clk);
      cs_rise = 1'b0;
      chk(busy == (n > 0), "R8 busy after cs_rise", int'(busy), int'(n > 0));
      if (noise) begin
         // R9: inputs during busy must leave no trace
         start_vld = 1'b1; start_addr = AW'(10'h2A0);
         @(negedge clk);
         start_vld = 1'b0;
         for (int i = 0; i < 3; i++) begin
            byte_vld = 1'b1; byte_data = 8'hEE;
            @(negedge clk);
         end
         byte_vld = 1'b0;
         cs_rise = 1'b1;
         @(negedge clk);
         cs_rise = 1'b0;
      end
      if (n > 0) wait_done();
   endtask

   task automatic expect_quiet(input string req);
      for (int i = 0; i < WC + 4; i++) begin
         @(negedge clk);
         chk(!busy, req, int'(busy), 0);
      end
   endtask

   initial begin
      #1000000;
      if (!finished) begin
         chk(0, "watchdog expired", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!busy && !done && !commit_vld, "R1 reset outputs", int'({busy, done, commit_vld}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !commit_vld, "R1 after release", int'({busy, done, commit_vld}), 0);

      session(10'h025, 1, 8'h11, 0);   // R2 single byte at its start address
      session(10'h040, 4, 8'h20, 0);   // R3 consecutive bytes
      session(10'h03E, 5, 8'h30, 0);   // R4 fold to column 0 of page 3
      session(10'h050, 18, 8'h40, 0);  // R6 columns 0,1 written twice
      session(10'h3FF, 2, 8'h55, 0);   // R4 last page of the space

      // R7 chip select rise without data
      start_vld = 1'b1; start_addr = 10'h120;
      @(negedge clk);
      start_vld = 1'b0;
      cs_rise = 1'b1;
      @(negedge clk);
      cs_rise = 1'b0;
      expect_quiet("R7 no write without bytes");

      // R9 stimulus while busy is ignored
      session(10'h107, 3, 8'h60, 1);
      byte_vld = 1'b1; byte_data = 8'h99;
      @(negedge clk);
      byte_vld = 1'b0;
      cs_rise = 1'b1;
      @(negedge clk);
      cs_rise = 1'b0;
      expect_quiet("R9 start during busy not kept");

      // R10 bytes with no open fill
      for (int i = 0; i < 4; i++) begin
         byte_vld = 1'b1; byte_data = DW'(i);
         @(negedge clk);
      end
      byte_vld = 1'b0;
      cs_rise = 1'b1;
      @(negedge clk);
      cs_rise = 1'b0;
      expect_quiet("R10 bytes without start");

      session(10'h2C9, 16, 8'h70, 0);  // R4 full page from mid-page
      chk(exp_q.size() == 0, "R5 scoreboard empty", exp_q.size(), 0);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule